// File: doc/BRIEF.md
# SPI Register Access Slave

This block is the serial front end of a peripheral's register bank. An external host talks to it over a four-wire SPI link in mode 0, MSB first, and reaches a 64-entry byte-wide register space. Every chip-select frame opens with a header byte. Bit 7 of the header selects read (1) or write (0). Bits 6:1 carry the 6-bit register number. Bit 0 is a don't-care that hosts send as zero. The block drives a simple register port: a one-cycle write strobe with address and data, and a one-cycle read strobe with address. The attached register bank returns the read data on the same cycle as the read strobe. A FIFO can sit behind one address and use the read strobe to pop and the write strobe to push.

A write frame carries one header followed by any number of data bytes, and all of them go to the header's address. On a read, the data comes back one byte after the header that asked for it. A burst read therefore repeats the read header once per wanted byte, ends with a 0x00 byte, and the host throws away the first byte it receives. The SPI pins are brought into the system clock domain through synchronisers. All protocol state lives in the system clock domain, and chip-select going high abandons whatever was in progress.

Top module: `spi_reg_slave`

## Requirements
- R1: The header byte is decoded as: bit 7 set for read, clear for write; bits 6:1 the register address; bit 0 ignored.
- R2: A write frame of header plus one data byte produces exactly one `reg_we_o` pulse, with `reg_addr_o` equal to the header address and `reg_wdata_o` equal to the data byte.
- R3: In a read frame (read header, then any byte), the addressed value is shifted out MSB first during the second byte. The byte returned during the header is 0x00.
- R4: In a write frame, every data byte after the header is written to the same address with its own `reg_we_o` pulse, in arrival order.
- R5: Each read header received in a frame fetches its register with one `reg_re_o` pulse and returns the value in the next byte. A received byte with bit 7 clear after a read header fetches nothing and returns 0x00 in the next byte.
- R6: Addresses flagged in `RSVD_MASK` produce no `reg_we_o` and no `reg_re_o`, and reads from them return 0x00. The default reserved set includes 0x00, 0x0F and 0x3F.
- R7: Raising `cs_ni` discards a partly shifted byte and returns `miso_o` to 0. The next frame treats its first byte as a header.
- R8: Under reset, `miso_o`, `reg_we_o` and `reg_re_o` are 0.
- R9: `reg_we_o` and `reg_re_o` are each single-cycle pulses and are never high together.
- R10: `mosi_i` is sampled on rising SCK. `miso_o` changes only after a falling SCK edge or a byte reload. The system clock must run at least eight times faster than SCK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | SPI serial clock from host |
| cs_ni | input | 1 | SPI chip select, active low |
| mosi_i | input | 1 | Serial data from host |
| miso_o | output | 1 | Serial data to host |
| reg_we_o | output | 1 | One-cycle register write strobe |
| reg_re_o | output | 1 | One-cycle register read/pop strobe |
| reg_addr_o | output | 6 | Register address for either strobe |
| reg_wdata_o | output | 8 | Write data, valid with `reg_we_o` |
| reg_rdata_i | input | 8 | Read data, valid in the `reg_re_o` cycle |

## Verification
The assertions check on every cycle that the strobes are single-cycle and never overlap. They also check that no strobe ever names a reserved address, that MISO holds still between falling SCK edges and byte reloads, and that it is zero while chip select is high. Only the bench's frames can show that bytes land at the right address with the right value. The same holds for the one-byte read lag, for burst reads whose header changes address from byte to byte, for FIFO streaming at a single address, and for a frame cut short mid-byte leaving no trace in the register bank.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 8;
  localparam int REG_N  = 1 << ADDR_W;

  typedef logic [ADDR_W-1:0] reg_addr_t;
  typedef logic [DATA_W-1:0] reg_byte_t;

  function automatic logic hdr_is_read(reg_byte_t b);
    return b[DATA_W-1];
  endfunction

  function automatic reg_addr_t hdr_addr(reg_byte_t b);
    return b[ADDR_W:1];
  endfunction
endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic cs_ni,
  input  logic mosi_i,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic cs_act_o,
  output logic mosi_o
);
  localparam int LAST = SYNC_STAGES - 1;

  // {cs_n, sck, mosi}
  logic [2:0] stg_q [SYNC_STAGES];
  logic       sck_d_q;
  logic       sck_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < SYNC_STAGES; i++) stg_q[i] <= 3'b100;
      sck_d_q <= 1'b0;
    end else begin
      stg_q[0] <= {cs_ni, sck_i, mosi_i};
      for (int i = 1; i < SYNC_STAGES; i++) stg_q[i] <= stg_q[i-1];
      sck_d_q <= stg_q[LAST][1];
    end
  end

  assign sck_s      = stg_q[LAST][1];
  assign cs_act_o   = ~stg_q[LAST][2];
  assign mosi_o     = stg_q[LAST][0];
  assign sck_rise_o = cs_act_o &  sck_s & ~sck_d_q;
  assign sck_fall_o = cs_act_o & ~sck_s &  sck_d_q;
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter
  import spi_reg_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      cs_act_i,
  input  logic      rise_i,
  input  logic      fall_i,
  input  logic      mosi_i,
  input  logic      ld_i,
  input  reg_byte_t ld_byte_i,
  output logic      byte_done_o,
  output reg_byte_t rx_byte_o,
  output logic      miso_o
);
  logic [2:0] bit_cnt_q;
  reg_byte_t  rx_q, tx_q;
  logic       done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      done_q    <= 1'b0;
    end else if (!cs_act_i) begin
      bit_cnt_q <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (rise_i) begin
        rx_q      <= {rx_q[DATA_W-2:0], mosi_i};
        bit_cnt_q <= bit_cnt_q + 3'd1;
        if (bit_cnt_q == 3'd7) done_q <= 1'b1;
      end
      // no shift on the fall that follows a byte boundary: new MSB already loaded
      if (ld_i) tx_q <= ld_byte_i;
      else if (fall_i && bit_cnt_q != 3'd0) tx_q <= {tx_q[DATA_W-2:0], 1'b0};
    end
  end

  assign byte_done_o = done_q;
  assign rx_byte_o   = rx_q;
  assign miso_o      = tx_q[DATA_W-1];

  // R10
  miso_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_act_i && !fall_i && !ld_i |=> $stable(miso_o));
  // R7
  miso_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_act_i |=> !miso_o);
endmodule

// File: rtl/spi_txn_ctrl.sv
module spi_txn_ctrl
  import spi_reg_pkg::*;
#(
  parameter logic [REG_N-1:0] RSVD_MASK = '0
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      cs_act_i,
  input  logic      done_i,
  input  reg_byte_t rx_byte_i,
  input  reg_byte_t reg_rdata_i,
  output logic      reg_we_o,
  output logic      reg_re_o,
  output reg_addr_t reg_addr_o,
  output reg_byte_t reg_wdata_o,
  output logic      tx_ld_o,
  output reg_byte_t tx_byte_o
);
  logic      first_q, wr_mode_q, pend_wr_q, pend_rd_q;
  reg_addr_t addr_q;
  reg_byte_t wdata_q;
  reg_addr_t hdr_a;

  assign hdr_a = hdr_addr(rx_byte_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q   <= 1'b1;
      wr_mode_q <= 1'b0;
      pend_wr_q <= 1'b0;
      pend_rd_q <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
    end else begin
      pend_wr_q <= 1'b0;
      pend_rd_q <= 1'b0;
      if (!cs_act_i) begin
        first_q   <= 1'b1;
        wr_mode_q <= 1'b0;
      end else if (done_i) begin
        if (first_q || !wr_mode_q) begin
          first_q <= 1'b0;
          if (hdr_is_read(rx_byte_i)) begin
            addr_q    <= hdr_a;
            pend_rd_q <= !RSVD_MASK[hdr_a];
          end else if (first_q) begin
            wr_mode_q <= 1'b1;
            addr_q    <= hdr_a;
          end
        end else begin
          wdata_q   <= rx_byte_i;
          pend_wr_q <= !RSVD_MASK[addr_q];
        end
      end
    end
  end

  assign reg_we_o    = pend_wr_q;
  assign reg_re_o    = pend_rd_q;
  assign reg_addr_o  = addr_q;
  assign reg_wdata_o = wdata_q;
  // clear at each byte boundary, then fill with fetched data one cycle later
  assign tx_ld_o     = done_i | pend_rd_q;
  assign tx_byte_o   = pend_rd_q ? reg_rdata_i : '0;

  // R9
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_o && reg_re_o));
  // R9
  we_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);
  // R9
  re_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_re_o |=> !reg_re_o);
  // R6
  rsvd_we_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> !RSVD_MASK[reg_addr_o]);
  // R6
  rsvd_re_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_re_o |-> !RSVD_MASK[reg_addr_o]);
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_reg_pkg::*;
#(
  parameter int               SYNC_STAGES = 2,
  parameter logic [REG_N-1:0] RSVD_MASK   = 64'hF001_0029_4C01_8001
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sck_i,
  input  logic       cs_ni,
  input  logic       mosi_i,
  output logic       miso_o,
  output logic       reg_we_o,
  output logic       reg_re_o,
  output logic [5:0] reg_addr_o,
  output logic [7:0] reg_wdata_o,
  input  logic [7:0] reg_rdata_i
);
  logic      rise, fall, cs_act, mosi_s, done, tx_ld;
  reg_byte_t rx_byte, tx_byte;

  spi_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .sck_i, .cs_ni, .mosi_i,
    .sck_rise_o(rise), .sck_fall_o(fall), .cs_act_o(cs_act), .mosi_o(mosi_s)
  );

  spi_byte_shifter u_shift (
    .clk_i, .rst_ni,
    .cs_act_i(cs_act), .rise_i(rise), .fall_i(fall), .mosi_i(mosi_s),
    .ld_i(tx_ld), .ld_byte_i(tx_byte),
    .byte_done_o(done), .rx_byte_o(rx_byte), .miso_o(miso_o)
  );

  spi_txn_ctrl #(.RSVD_MASK(RSVD_MASK)) u_ctrl (
    .clk_i, .rst_ni,
    .cs_act_i(cs_act), .done_i(done), .rx_byte_i(rx_byte), .reg_rdata_i(reg_rdata_i),
    .reg_we_o(reg_we_o), .reg_re_o(reg_re_o), .reg_addr_o(reg_addr_o),
    .reg_wdata_o(reg_wdata_o), .tx_ld_o(tx_ld), .tx_byte_o(tx_byte)
  );
endmodule

// File: tb/spi_reg_slave_tb.sv
`timescale 1ns/1ps
module spi_reg_slave_tb;
  localparam int HALF = 80;
  localparam logic [5:0] FIFO_A = 6'h09;
  // {addr, data, reserved}
  localparam logic [14:0] VEC [6] = '{
    {6'h01, 8'h5A, 1'b0}, {6'h0C, 8'hC3, 1'b0}, {6'h2A, 8'h80, 1'b0},
    {6'h3B, 8'h01, 1'b0}, {6'h0F, 8'h77, 1'b1}, {6'h3F, 8'hEE, 1'b1}};

  logic clk = 0, rst_n = 0, sck = 0, cs_n = 1, mosi = 0;
  logic miso, we, re;
  logic [5:0] addr;
  logic [7:0] wdata, rdata;
  logic [7:0] mem [64];
  logic [7:0] fifo [16];
  logic [3:0] wr_ptr, rd_ptr;
  int we_cnt, re_cnt, n_chk = 0, n_fail = 0;
  logic [7:0] tx_buf [16];
  logic [7:0] rx_buf [16];
  bit done_flag = 0;

  always #5 clk = ~clk;

  spi_reg_slave u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .cs_ni(cs_n), .mosi_i(mosi),
    .miso_o(miso), .reg_we_o(we), .reg_re_o(re), .reg_addr_o(addr),
    .reg_wdata_o(wdata), .reg_rdata_i(rdata)
  );

  assign rdata = (addr == FIFO_A) ? fifo[rd_ptr] : mem[addr];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] <= 8'h00;
      for (int i = 0; i < 16; i++) fifo[i] <= 8'h00;
      wr_ptr <= 0; rd_ptr <= 0; we_cnt <= 0; re_cnt <= 0;
    end else begin
      if (we) begin
        we_cnt <= we_cnt + 1;
        if (addr == FIFO_A) begin fifo[wr_ptr] <= wdata; wr_ptr <= wr_ptr + 1; end
        else mem[addr] <= wdata;
      end
      if (re) begin
        re_cnt <= re_cnt + 1;
        if (addr == FIFO_A) rd_ptr <= rd_ptr + 1;
      end
    end
  end

  function automatic logic [7:0] wh(logic [5:0] a); return {1'b0, a, 1'b0}; endfunction
  function automatic logic [7:0] rh(logic [5:0] a); return {1'b1, a, 1'b0}; endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic spi_frame(input int nbits);
    for (int i = 0; i < 16; i++) rx_buf[i] = 8'h00;
    @(negedge clk);
    cs_n = 0;
    #(HALF);
    for (int k = 0; k < nbits; k++) begin
      mosi = tx_buf[k/8][7 - (k%8)];
      #(HALF);
      rx_buf[k/8][7 - (k%8)] = miso;
      sck = 1;
      #(HALF);
      sck = 0;
    end
    #(HALF);
    cs_n = 1; mosi = 0;
    #(4*HALF);
  endtask

  task automatic finish_run;
    if (!done_flag) begin
      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    finish_run();
  end

  initial begin
    int w0, r0;
    repeat (4) @(negedge clk);
    // R8
    check("R8 miso in reset", miso, 0);
    check("R8 we in reset", we, 0);
    check("R8 re in reset", re, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R8 miso after reset", miso, 0);

    // table: single write then single read (R2, R3, R6)
    for (int v = 0; v < 6; v++) begin
      logic [5:0] a; logic [7:0] d; logic rs;
      {a, d, rs} = VEC[v];
      w0 = we_cnt;
      tx_buf[0] = wh(a); tx_buf[1] = d;
      spi_frame(16);
      check(rs ? "R6 reserved write strobe" : "R2 write strobe count", we_cnt - w0, rs ? 0 : 1);
      r0 = re_cnt;
      tx_buf[0] = rh(a); tx_buf[1] = 8'h00;
      spi_frame(16);
      check("R3 first byte zero", rx_buf[0], 0);
      check(rs ? "R6 reserved reads zero" : "R3 read value", rx_buf[1], rs ? 0 : d);
      check(rs ? "R6 reserved no pop" : "R5 one pop", re_cnt - r0, rs ? 0 : 1);
    end

    // R1: header bit 0 is ignored
    tx_buf[0] = wh(6'h14) | 8'h01; tx_buf[1] = 8'h3C;
    spi_frame(16);
    tx_buf[0] = rh(6'h14); tx_buf[1] = 8'h00;
    spi_frame(16);
    check("R1 bit0 ignored", rx_buf[1], 8'h3C);

    // R4: burst write into FIFO port
    w0 = we_cnt;
    tx_buf[0] = wh(FIFO_A); tx_buf[1] = 8'h11; tx_buf[2] = 8'h22; tx_buf[3] = 8'h33;
    spi_frame(32);
    check("R4 burst write strobes", we_cnt - w0, 3);
    check("R4 fifo order", {fifo[0], fifo[1], fifo[2]}, 24'h112233);

    // R5: burst read streams FIFO
    r0 = re_cnt;
    tx_buf[0] = rh(FIFO_A); tx_buf[1] = rh(FIFO_A); tx_buf[2] = rh(FIFO_A); tx_buf[3] = 8'h00;
    spi_frame(32);
    check("R5 burst read byte0", rx_buf[0], 0);
    check("R5 burst read data", {rx_buf[1], rx_buf[2], rx_buf[3]}, 24'h112233);
    check("R5 burst pops", re_cnt - r0, 3);

    // R4: burst write to plain register, last value stays
    w0 = we_cnt;
    tx_buf[0] = wh(6'h05); tx_buf[1] = 8'h01; tx_buf[2] = 8'h02; tx_buf[3] = 8'hA3;
    spi_frame(32);
    check("R4 same-address strobes", we_cnt - w0, 3);
    tx_buf[0] = rh(6'h05); tx_buf[1] = 8'h00;
    spi_frame(16);
    check("R4 last byte kept", rx_buf[1], 8'hA3);

    // R5: burst read with changing addresses
    tx_buf[0] = rh(6'h01); tx_buf[1] = rh(6'h0C); tx_buf[2] = 8'h00;
    spi_frame(24);
    check("R5 mixed addr first", rx_buf[1], 8'h5A);
    check("R5 mixed addr second", rx_buf[2], 8'hC3);

    // R5: non-read byte after read header terminates, returns zero
    r0 = re_cnt;
    tx_buf[0] = rh(6'h01); tx_buf[1] = 8'h00; tx_buf[2] = 8'h00;
    spi_frame(24);
    check("R5 terminator returns zero", rx_buf[2], 0);
    check("R5 terminator no pop", re_cnt - r0, 1);

    // R6: reserved burst read
    r0 = re_cnt;
    tx_buf[0] = rh(6'h00); tx_buf[1] = rh(6'h00); tx_buf[2] = 8'h00;
    spi_frame(24);
    check("R6 reserved burst zero", {rx_buf[1], rx_buf[2]}, 0);
    check("R6 reserved burst no pop", re_cnt - r0, 0);

    // R7: abort inside header, then abort inside data
    tx_buf[0] = rh(6'h05);
    spi_frame(4);
    check("R7 miso low after abort", miso, 0);
    w0 = we_cnt;
    tx_buf[0] = wh(6'h05); tx_buf[1] = 8'h44;
    spi_frame(16);
    check("R7 next frame header decoded", we_cnt - w0, 1);
    w0 = we_cnt;
    tx_buf[0] = wh(6'h05); tx_buf[1] = 8'hFF;
    spi_frame(13);
    check("R7 partial data dropped", we_cnt - w0, 0);
    tx_buf[0] = rh(6'h05); tx_buf[1] = 8'h00;
    spi_frame(16);
    check("R7 register unchanged", rx_buf[1], 8'h44);

    finish_run();
  end
endmodule